// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address presented to a synchronous memory array during a four-beat burst. A burst begins when either of two start strobes is high at a clock edge: one comes from the processor, the other from the cache controller. On that edge the external address is captured and appears on the output. After that, a two-bit beat counter moves the two low address bits forward on each edge where the advance input is high. The upper address bits never change within a burst.

A mode input, sampled only on the edge that starts a burst, chooses the beat order. Linear order counts the low field up by one, wrapping modulo four. Interleaved order XORs the starting low bits with the beat count. After four advances the address returns to the starting address. The upper bits are never carried into.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and at the first edge after it, `addr_out` is all zeros.
- R2: If `proc_start` or `cache_start` is high at a clock edge, `addr_out` equals the `ext_addr` sampled at that edge from that edge on.
- R3: If both start strobes are high together, exactly one load of `ext_addr` takes place. A start strobe also overrides `adv` in the same cycle: the address loads and does not step.
- R4: Linear order (`order_ilv` = 0 at the start edge): each edge with `adv` high and no start strobe sets `addr_out[1:0]` to its previous value plus one, modulo 4. A start low field of 2 gives 2,3,0,1.
- R5: Interleaved order (`order_ilv` = 1 at the start edge): after k advances, `addr_out[1:0]` equals the start low field XOR (k mod 4). A start of 1 gives 1,0,3,2, and a start of 2 gives 2,3,0,1.
- R6: Between loads, `addr_out[ADDR_W-1:2]` never changes. The fourth advance returns `addr_out` to the burst's starting address.
- R7: An edge with `adv` low and no start strobe leaves `addr_out` unchanged.
- R8: `order_ilv` has no effect except on a start edge. Changing it during a burst does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | Burst start address |
| proc_start | input | 1 | Processor start strobe, active high |
| cache_start | input | 1 | Cache-controller start strobe, active high |
| adv | input | 1 | Advance to the next beat, active high |
| order_ilv | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current memory address |

## Verification
The assertions assume that the inputs are free of X once reset is released. They also assume that `ext_addr` is meaningful only on a start edge, so the checks constrain it only there. The stimulus changes every input on the falling edge, so each value is stable through the next rising edge. It mixes directed bursts, including strobe collisions, start-plus-advance and a mid-burst order flip, with a pseudo-random run. Across that run the strobes, advance and order bits are toggled freely.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Beat ordering captured at burst start
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Per-cycle command decoded from the strobes and advance input
    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_pkg::*;
(
    input  logic proc_start,
    input  logic cache_start,
    input  logic adv,
    output cmd_e cmd
);

    // The processor strobe is tested first. Both strobes request the same
    // load, so a collision still results in a single capture. A load always
    // wins over an advance request.
    always_comb begin
        if (proc_start) begin
            cmd = CMD_LOAD;
        end else if (cache_start) begin
            cmd = CMD_LOAD;
        end else if (adv) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_IDLE;
        end
    end

endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_d, count_q;

    // Wraps modulo 2**CNT_W, so the beat after the last returns to zero
    always_comb begin
        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (step) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/beat_order_map.sv
module beat_order_map
    import burst_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] base,
    input  logic [CNT_W-1:0] count,
    input  order_e           order,
    output logic [CNT_W-1:0] low
);

    logic [CNT_W-1:0] lin_low;
    logic [CNT_W-1:0] ilv_low;

    assign lin_low = base + count;

    // Interleaved order: each bit of the start field is flipped by the
    // matching bit of the beat count
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
        assign ilv_low[b] = base[b] ^ count[b];
    end

    assign low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              proc_start,
    input  logic              cache_start,
    input  logic              adv,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int HI_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [CNT_W-1:0] base;
        order_e           order;
    } burst_state_t;

    burst_state_t     s_d, s_q;
    cmd_e             cmd;
    logic [CNT_W-1:0] beat;
    logic [CNT_W-1:0] low;
    order_e           cur_order;

    burst_cmd_decode u_decode (
        .proc_start  (proc_start),
        .cache_start (cache_start),
        .adv         (adv),
        .cmd         (cmd)
    );

    beat_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cmd == CMD_LOAD),
        .step  (cmd == CMD_STEP),
        .count (beat)
    );

    always_comb begin
        s_d = s_q;
        if (cmd == CMD_LOAD) begin
            s_d.hi    = ext_addr[ADDR_W-1:CNT_W];
            s_d.base  = ext_addr[CNT_W-1:0];
            s_d.order = order_ilv ? ORD_INTERLEAVE : ORD_LINEAR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{hi: '0, base: '0, order: ORD_LINEAR};
        end else begin
            s_q <= s_d;
        end
    end

    beat_order_map #(.CNT_W(CNT_W)) u_map (
        .base  (s_q.base),
        .count (beat),
        .order (s_q.order),
        .low   (low)
    );

    assign cur_order = s_q.order;
    assign addr_out  = {s_q.hi, low};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              proc_start,
    input logic              cache_start,
    input logic              adv,
    input order_e            cur_order,
    input logic [ADDR_W-1:0] addr_out
);

    logic start;
    assign start = proc_start | cache_start;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> addr_out == $past(ext_addr)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !adv) |=> $stable(addr_out)); // R7

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(addr_out[ADDR_W-1:CNT_W])); // R6

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && adv && cur_order == ORD_LINEAR)
        |=> addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + 1'b1)); // R4

    AST_ILV_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && adv && cur_order == ORD_INTERLEAVE)
        |=> addr_out[CNT_W-1:0] != $past(addr_out[CNT_W-1:0])); // R5

    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(cur_order)); // R8

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_addr    (ext_addr),
    .proc_start  (proc_start),
    .cache_start (cache_start),
    .adv         (adv),
    .cur_order   (cur_order),
    .addr_out    (addr_out)
);

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/100ps
module burst_addr_gen_bench;

    localparam int ADDR_W = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              proc_start = 1'b0;
    logic              cache_start = 1'b0;
    logic              adv = 1'b0;
    logic              order_ilv = 1'b0;
    logic [ADDR_W-1:0] addr_out;

    int checks = 0;
    int errors = 0;

    logic [ADDR_W-1:0] exp_q[$];
    string             tag_q[$];

    // Reference model state
    logic [ADDR_W-3:0] m_hi = '0;
    logic [1:0]        m_base = '0;
    logic [1:0]        m_cnt = '0;
    logic              m_ilv = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_burst_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_addr    (ext_addr),
        .proc_start  (proc_start),
        .cache_start (cache_start),
        .adv         (adv),
        .order_ilv   (order_ilv),
        .addr_out    (addr_out)
    );

    function automatic logic [ADDR_W-1:0] model_addr();
        logic [1:0] lo;
        lo = m_ilv ? (m_base ^ m_cnt) : 2'(m_base + m_cnt);
        return {m_hi, lo};
    endfunction

    task automatic check(input string tag, input logic [ADDR_W-1:0] act,
                         input logic [ADDR_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: addr_out=%h expected %h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected address
    task automatic drive(input string tag, input logic p, input logic c,
                         input logic a, input logic m,
                         input logic [ADDR_W-1:0] ea);
        @(negedge clk);
        proc_start  = p;
        cache_start = c;
        adv         = a;
        order_ilv   = m;
        ext_addr    = ea;
        if (p || c) begin
            m_hi   = ea[ADDR_W-1:2];
            m_base = ea[1:0];
            m_cnt  = 2'd0;
            m_ilv  = m;
        end else if (a) begin
            m_cnt = m_cnt + 2'd1;
        end
        @(posedge clk);
        #0.5;
        exp_q.push_back(model_addr());
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each queued expectation one step after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), addr_out, exp_q.pop_front());
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", addr_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1 after reset", addr_out, '0);

        // R2 + R4 + R6: processor start, linear, start 2 -> 2,3,0,1 then back to 2
        drive("R2 proc load", 1, 0, 0, 0, 17'h12342);
        for (int i = 0; i < 4; i++) drive("R4 R6 linear step", 0, 0, 1, 0, 17'h0);

        // R7: advance low holds
        for (int i = 0; i < 3; i++) drive("R7 hold", 0, 0, 0, 1, 17'h1FFFF);
        drive("R4 after hold", 0, 0, 1, 0, 17'h0);

        // R2 + R5 + R6: cache start, interleaved, start 1 -> 1,0,3,2 then 1
        drive("R2 cache load", 0, 1, 0, 1, 17'h0AB71);
        for (int i = 0; i < 4; i++) drive("R5 R6 ilv step", 0, 0, 1, 1, 17'h0);

        // R5: interleaved from start 2 and start 3
        drive("R2 cache load s2", 0, 1, 0, 1, 17'h15556);
        for (int i = 0; i < 4; i++) drive("R5 ilv s2", 0, 0, 1, 0, 17'h0);
        drive("R2 proc load s3", 1, 0, 0, 1, 17'h00003);
        for (int i = 0; i < 4; i++) drive("R5 ilv s3", 0, 0, 1, 1, 17'h0);

        // R8: order flipped mid-burst has no effect
        drive("R2 load linear s1", 1, 0, 0, 0, 17'h1C001);
        for (int i = 0; i < 4; i++) drive("R8 order flip", 0, 0, 1, 1, 17'h0);
        drive("R2 load ilv s3", 0, 1, 0, 1, 17'h03333);
        for (int i = 0; i < 4; i++) drive("R8 order flip ilv", 0, 0, 1, 0, 17'h0);

        // R3: collisions and start-with-advance
        drive("R3 both strobes", 1, 1, 0, 0, 17'h0F0F2);
        drive("R3 step", 0, 0, 1, 0, 17'h0);
        drive("R3 both strobes adv", 1, 1, 1, 1, 17'h10101);
        drive("R3 step", 0, 0, 1, 1, 17'h0);
        drive("R3 cache with adv", 0, 1, 1, 0, 17'h07FFE);
        drive("R3 proc with adv", 1, 0, 1, 1, 17'h1234D);
        drive("R3 step", 0, 0, 1, 1, 17'h0);

        // Mixed pseudo-random run
        for (int i = 0; i < 300; i++) begin
            logic p, c, a, m;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            p = (lfsr[3:0] == 4'd0);
            c = (lfsr[7:4] == 4'd5);
            a = lfsr[8] | lfsr[9];
            m = lfsr[10];
            drive("R2 R6 R7 random", p, c, a, m, {lfsr[0], lfsr});
        end

        @(posedge clk);
        #2;
        finish_run();
    end

endmodule